// File: doc/BRIEF.md
# Dual-Resolution Watchdog Timer

This block is a host-programmable watchdog. An 8-bit count register sets the timeout, and the count is read either in seconds or in minutes. A prescaler divides the input clock down to a one-second tick. In minute mode a second divider turns a fixed number of those ticks into one unit. When the countdown reaches its end, the block sets a sticky timeout flag. It can also drive an active-low system reset pulse of programmable length, and it can raise a one-cycle wake event while the power-saving mode is active.

The host reaches the block through three write strobes:
- The configuration write carries the enable, the unit select, the reset enable, the wake enable and the pulse length.
- The count write loads the timeout.
- The status clear writes a 1 to the timeout flag.

A small state machine controls the countdown. Its states are `WD_IDLE` (disabled), `WD_RUN` (counting) and `WD_EXPIRED` (timed out, counter halted). Its transitions are:
- enable: `WD_IDLE` to `WD_RUN`, which loads the stored count.
- reload: `WD_RUN` or `WD_EXPIRED` to `WD_RUN`, on a count write or on a re-enable.
- expire: `WD_RUN` to `WD_EXPIRED`, on the last unit tick.
- disable: any state to `WD_IDLE`.

Top module: `dual_unit_watchdog`

## Requirements
- R1: After reset, sys_rst_n is 1, timeout_sts is 0, wake_evt is 0 and units_left is 0.
- R2: With cfg_unit_min=0, expiry takes effect on the clock edge exactly N*CLK_PER_SEC cycles after the loading edge. N is the count value, and a count value of 0 means N=256. On the edge before expiry, units_left is 1. On the expiry edge, units_left becomes 0.
- R3: With cfg_unit_min=1, expiry takes effect exactly N*CLK_PER_SEC*SEC_PER_MIN cycles after the loading edge. N is encoded as in R2.
- R4: A count write while the timer is enabled reloads units_left and restarts the unit tick from zero. Any partly elapsed tick is discarded.
- R5: timeout_sts is set on expiry and stays set until sts_clr is written as 1. After expiry the counter stays at 0 and does not expire again until it is reloaded or re-enabled.
- R6: With cfg_rst_en=1, sys_rst_n goes low starting on the expiry edge and stays low for exactly L cycles, where L is cfg_pulse_len and the value 0 acts as 1. With cfg_rst_en=0, sys_rst_n stays 1.
- R7: wake_evt is high for exactly one cycle after the expiry edge, and only when cfg_wake_en and psave_en are both 1. Otherwise it stays 0.
- R8: A configuration write with cfg_en=0 stops the countdown on that edge. This holds even when a unit tick is due on the same edge: no expiry happens, and units_left keeps its value.
- R9: A configuration write with cfg_en=1, made while the timer is disabled or expired, reloads the counter from the stored count.
- R10: A count write while the timer is disabled stores the value but does not change units_left and does not start the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Timer enable |
| cfg_unit_min | input | 1 | Unit select: 0 = seconds, 1 = minutes |
| cfg_rst_en | input | 1 | Enables the reset pulse on expiry |
| cfg_wake_en | input | 1 | Enables the wake event on expiry |
| cfg_pulse_len | input | PULSE_W | Reset pulse length in clock cycles |
| cnt_wr | input | 1 | Count write strobe |
| cnt_data | input | 8 | Timeout in units (0 = 256) |
| sts_clr | input | 1 | Write-1 clear of timeout_sts |
| psave_en | input | 1 | Power-saving mode active |
| units_left | output | 9 | Remaining units |
| timeout_sts | output | 1 | Sticky timeout flag |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| wake_evt | output | 1 | One-cycle wake event |

## Verification
The hardest case to reach from the ports is a disable that lands on the very edge where the final unit tick would expire the timer. The disable has to win over the expiry. The bench counts cycles from the enable edge and drives the disabling configuration write so that it is sampled on edge N*CLK_PER_SEC. It then checks that the flag, the reset pulse and the wake event stay quiet and that units_left still reads 1. With the prescaler overridden to a small divisor, the bench can also sweep the count values in both units, including the 256-unit encoding.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_IDLE    = 2'd0,
        WD_RUN     = 2'd1,
        WD_EXPIRED = 2'd2
    } wd_state_e;

    // An 8-bit count value of zero stands for the full 256 units.
    function automatic logic [8:0] wd_units(input logic [7:0] code);
        return (code == 8'd0) ? 9'd256 : {1'b0, code};
    endfunction

endpackage

// File: rtl/wdt_unit_tick.sv
module wdt_unit_tick #(
    parameter int CLK_PER_SEC = 24_000_000,
    parameter int SEC_PER_MIN = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic unit_min,
    output logic unit_tick
);
    localparam int PRE_W = (CLK_PER_SEC > 1) ? $clog2(CLK_PER_SEC) : 1;
    localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_SEC - 1);
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);

    logic [PRE_W-1:0] pre_q;
    logic [SEC_W-1:0] sec_q;
    logic             sec_tick;
    logic             min_tick;

    assign sec_tick  = run && (pre_q == PRE_LAST);
    assign min_tick  = sec_tick && (sec_q == SEC_LAST);
    assign unit_tick = unit_min ? min_tick : sec_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            sec_q <= '0;
        end else if (!run || restart) begin
            pre_q <= '0;
            sec_q <= '0;
        end else begin
            pre_q <= sec_tick ? '0 : pre_q + 1'b1;
            if (sec_tick) begin
                sec_q <= min_tick ? '0 : sec_q + 1'b1;
            end
        end
    end

    // R2: the second prescaler never passes its last count
    a_r2_prescale_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pre_q) < CLK_PER_SEC);

    // R3: the minute divider never passes its last count
    a_r3_minute_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sec_q) < SEC_PER_MIN);

endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
    parameter int PULSE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [PULSE_W-1:0] len,
    output logic               pulse_n
);
    logic [PULSE_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= (len == '0) ? PULSE_W'(1) : len;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pulse_n = (cnt_q == '0);

    // R6: once started, the pulse counter falls by one every cycle
    a_r6_pulse_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && cnt_q != '0) |=> (cnt_q == PULSE_W'($past(cnt_q) - 1'b1)));

endmodule

// File: rtl/dual_unit_watchdog.sv
module dual_unit_watchdog
    import wdt_pkg::*;
#(
    parameter int CLK_PER_SEC = 24_000_000,
    parameter int SEC_PER_MIN = 60,
    parameter int PULSE_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_en,
    input  logic               cfg_unit_min,
    input  logic               cfg_rst_en,
    input  logic               cfg_wake_en,
    input  logic [PULSE_W-1:0] cfg_pulse_len,
    input  logic               cnt_wr,
    input  logic [7:0]         cnt_data,
    input  logic               sts_clr,
    input  logic               psave_en,
    output logic [8:0]         units_left,
    output logic               timeout_sts,
    output logic               sys_rst_n,
    output logic               wake_evt
);
    wd_state_e          state_q, state_d;
    logic [7:0]         count_q;
    logic [8:0]         units_q, units_d;
    logic               unit_min_q, rst_en_q, wake_en_q;
    logic [PULSE_W-1:0] pulse_len_q;
    logic               sts_q, wake_q;
    logic               en_next, reload, expire, unit_tick, running;
    logic [8:0]         load_units;

    assign running    = (state_q == WD_RUN);
    assign en_next    = cfg_wr ? cfg_en : (state_q != WD_IDLE);
    assign reload     = en_next && ((cfg_wr && cfg_en && !running) || cnt_wr);
    assign load_units = wd_units(cnt_wr ? cnt_data : count_q);

    wdt_unit_tick #(
        .CLK_PER_SEC(CLK_PER_SEC),
        .SEC_PER_MIN(SEC_PER_MIN)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .restart  (reload),
        .unit_min (unit_min_q),
        .unit_tick(unit_tick)
    );

    // Next state: disable beats reload, reload beats expiry.
    always_comb begin
        state_d = state_q;
        expire  = 1'b0;
        units_d = units_q;
        if (!en_next) begin
            state_d = WD_IDLE;
        end else if (reload) begin
            state_d = WD_RUN;
            units_d = load_units;
        end else begin
            unique case (state_q)
                WD_RUN: begin
                    if (unit_tick) begin
                        units_d = units_q - 9'd1;
                        if (units_q == 9'd1) begin
                            state_d = WD_EXPIRED;
                            expire  = 1'b1;
                        end
                    end
                end
                WD_IDLE, WD_EXPIRED: state_d = state_q;
                default:             state_d = WD_IDLE;
            endcase
        end
    end

    // State and register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= WD_IDLE;
            units_q     <= '0;
            count_q     <= '0;
            unit_min_q  <= 1'b0;
            rst_en_q    <= 1'b0;
            wake_en_q   <= 1'b0;
            pulse_len_q <= '0;
        end else begin
            state_q <= state_d;
            units_q <= units_d;
            if (cnt_wr) begin
                count_q <= cnt_data;
            end
            if (cfg_wr) begin
                unit_min_q  <= cfg_unit_min;
                rst_en_q    <= cfg_rst_en;
                wake_en_q   <= cfg_wake_en;
                pulse_len_q <= cfg_pulse_len;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q  <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            if (expire) begin
                sts_q <= 1'b1;
            end else if (sts_clr) begin
                sts_q <= 1'b0;
            end
            wake_q <= expire && wake_en_q && psave_en;
        end
    end

    wdt_rst_pulse #(
        .PULSE_W(PULSE_W)
    ) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (expire && rst_en_q),
        .len    (pulse_len_q),
        .pulse_n(sys_rst_n)
    );

    assign units_left  = units_q;
    assign timeout_sts = sts_q;
    assign wake_evt    = wake_q;

    // R5: the flag only rises together with the counter reaching zero
    a_r5_flag_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_sts) |-> (units_left == 9'd0));

    // R6: a reset pulse only begins when the reset function was enabled
    a_r6_pulse_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_n) |-> $past(rst_en_q));

    // R7: wake needs both enables and lasts a single cycle
    a_r7_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |-> ($past(wake_en_q) && $past(psave_en)));
    a_r7_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> !wake_evt);

    // R8: while disabled and not being enabled, the counter holds
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_IDLE && !(cfg_wr && cfg_en)) |=> $stable(units_left));

endmodule

// File: tb/test_dual_unit_watchdog.sv
module test_dual_unit_watchdog;
    localparam int CPS = 5;
    localparam int SPM = 3;
    localparam int PW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0, cfg_en = 1'b0, cfg_unit_min = 1'b0;
    logic          cfg_rst_en = 1'b0, cfg_wake_en = 1'b0;
    logic [PW-1:0] cfg_pulse_len = '0;
    logic          cnt_wr = 1'b0;
    logic [7:0]    cnt_data = '0;
    logic          sts_clr = 1'b0, psave_en = 1'b0;
    logic [8:0]    units_left;
    logic          timeout_sts, sys_rst_n, wake_evt;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    dual_unit_watchdog #(
        .CLK_PER_SEC(CPS),
        .SEC_PER_MIN(SPM),
        .PULSE_W    (PW)
    ) i_dual_unit_watchdog (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_en       (cfg_en),
        .cfg_unit_min (cfg_unit_min),
        .cfg_rst_en   (cfg_rst_en),
        .cfg_wake_en  (cfg_wake_en),
        .cfg_pulse_len(cfg_pulse_len),
        .cnt_wr       (cnt_wr),
        .cnt_data     (cnt_data),
        .sts_clr      (sts_clr),
        .psave_en     (psave_en),
        .units_left   (units_left),
        .timeout_sts  (timeout_sts),
        .sys_rst_n    (sys_rst_n),
        .wake_evt     (wake_evt)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge; each @(negedge) passes one rising edge.
    task automatic cfg(input bit en, input bit umin, input bit re, input bit we, input int len);
        cfg_en = en; cfg_unit_min = umin; cfg_rst_en = re; cfg_wake_en = we;
        cfg_pulse_len = PW'(len); cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wr_cnt(input int d);
        cnt_data = 8'(d); cnt_wr = 1'b1;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic clr();
        sts_clr = 1'b1;
        @(negedge clk);
        sts_clr = 1'b0;
    endtask

    task automatic arm(input int n, input bit umin, input bit re, input bit we, input int len);
        cfg(1'b0, umin, re, we, len);
        clr();
        wr_cnt(n);
        cfg(1'b1, umin, re, we, len);
    endtask

    // Called just after the loading edge; checks expiry T cycles later and the outputs that follow.
    task automatic expect_expiry(input string req, input int t, input bit rst_on, input int len,
                                 input bit wake_exp);
        int leff;
        leff = (len == 0) ? 1 : len;
        repeat (t - 1) @(negedge clk);
        chk(req, "units_left before expiry", int'(units_left), 1);
        chk(req, "timeout_sts before expiry", int'(timeout_sts), 0);
        @(negedge clk);
        chk(req, "timeout_sts at expiry", int'(timeout_sts), 1);
        chk(req, "units_left at expiry", int'(units_left), 0);
        chk("R6", "sys_rst_n at expiry", int'(sys_rst_n), rst_on ? 0 : 1);
        chk("R7", "wake_evt at expiry", int'(wake_evt), int'(wake_exp));
        if (rst_on) begin
            for (int k = 1; k <= leff; k++) begin
                @(negedge clk);
                if (k == 1) chk("R7", "wake_evt one cycle later", int'(wake_evt), 0);
                chk("R6", "sys_rst_n during pulse", int'(sys_rst_n), (k < leff) ? 0 : 1);
            end
        end else begin
            @(negedge clk);
            chk("R7", "wake_evt one cycle later", int'(wake_evt), 0);
            chk("R6", "sys_rst_n with reset disabled", int'(sys_rst_n), 1);
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "sys_rst_n", int'(sys_rst_n), 1);
        chk("R1", "timeout_sts", int'(timeout_sts), 0);
        chk("R1", "wake_evt", int'(wake_evt), 0);
        chk("R1", "units_left", int'(units_left), 0);

        // R2 seconds sweep, varied pulse lengths and wake gating
        for (int n = 0; n <= 12; n++) begin
            int nu;
            nu = (n == 0) ? 256 : n;
            psave_en = n[0];
            arm(n, 1'b0, 1'b1, 1'b1, n % 4);
            expect_expiry("R2", nu * CPS, 1'b1, n % 4, n[0]);
        end
        psave_en = 1'b1;
        arm(255, 1'b0, 1'b1, 1'b0, 2);
        expect_expiry("R2", 255 * CPS, 1'b1, 2, 1'b0);

        // R3 minutes sweep
        for (int n = 0; n <= 3; n++) begin
            int nu;
            nu = (n == 0) ? 256 : n;
            arm(n, 1'b1, 1'b1, 1'b1, 3);
            expect_expiry("R3", nu * CPS * SPM, 1'b1, 3, 1'b1);
        end

        // R6 reset function disabled: no pulse
        arm(2, 1'b0, 1'b0, 1'b1, 4);
        expect_expiry("R6", 2 * CPS, 1'b0, 4, 1'b1);

        // R4 reload mid-tick discards the partial tick
        arm(3, 1'b0, 1'b1, 1'b0, 1);
        repeat (7) @(negedge clk);
        wr_cnt(2);
        chk("R4", "units_left after reload", int'(units_left), 2);
        expect_expiry("R4", 2 * CPS, 1'b1, 1, 1'b0);

        // R5 sticky flag, counter halted, no second expiry
        repeat (40) @(negedge clk);
        chk("R5", "timeout_sts stays set", int'(timeout_sts), 1);
        chk("R5", "units_left stays zero", int'(units_left), 0);
        chk("R5", "no second pulse", int'(sys_rst_n), 1);
        clr();
        chk("R5", "timeout_sts after clear", int'(timeout_sts), 0);

        // R8 disable on the same edge as the final tick
        arm(2, 1'b0, 1'b1, 1'b1, 2);
        repeat (2 * CPS - 1) @(negedge clk);
        cfg(1'b0, 1'b0, 1'b1, 1'b1, 2);
        chk("R8", "timeout_sts after disable", int'(timeout_sts), 0);
        chk("R8", "units_left held", int'(units_left), 1);
        chk("R8", "sys_rst_n after disable", int'(sys_rst_n), 1);
        chk("R8", "wake_evt after disable", int'(wake_evt), 0);
        repeat (20) @(negedge clk);
        chk("R8", "units_left still held", int'(units_left), 1);
        chk("R8", "timeout_sts still clear", int'(timeout_sts), 0);

        // R9 re-enable reloads from the stored count (2)
        cfg(1'b1, 1'b0, 1'b1, 1'b1, 2);
        chk("R9", "units_left after re-enable", int'(units_left), 2);
        expect_expiry("R9", 2 * CPS, 1'b1, 2, 1'b1);

        // R10 count write while disabled only stores
        cfg(1'b0, 1'b0, 1'b1, 1'b0, 1);
        clr();
        wr_cnt(7);
        chk("R10", "units_left after disabled write", int'(units_left), 0);
        repeat (3 * CPS) @(negedge clk);
        chk("R10", "units_left still unchanged", int'(units_left), 0);
        chk("R10", "no expiry while disabled", int'(timeout_sts), 0);
        cfg(1'b1, 1'b0, 1'b1, 1'b0, 1);
        chk("R9", "units_left from stored count", int'(units_left), 7);
        expect_expiry("R10", 7 * CPS, 1'b1, 1, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule